// File: doc/BRIEF.md
# ASCII Hex Page-Memory Command Engine

This block turns a stream of received bytes into page-memory operations. It sits between a byte-wide serial receive and transmit path (8 data bits, 1 stop bit, no parity, serializer not included) and a page-memory handshake port. Four lower-case command letters select an operation: `e` erases a page, `w` writes a page, `r` reads a page and `g` requests a jump. Each letter is followed by a four-digit upper-case hex address and a carriage return. A write adds a second line that carries one page of 32 sixteen-bit words as 128 hex digits.

The engine keeps one page in a local buffer. It shifts incoming write data into that buffer, or loads the buffer from the memory's read bus, and then sends a read page back as hex text. Erase and write end with a single `.`, and that `.` is only sent once the memory has dropped its busy flag.

Malformed input is dropped without any reply. A `.` followed by a carriage return clears any half-entered command. While the engine is idle, filler bytes have no effect.

Top module: `hexpage_cmd_engine`

## Requirements
- R1: A command is one of the bytes `e`, `r`, `w`, `g` (lower case only). It is followed by exactly four hex digits from `0`-`9`/`A`-`F`, most significant digit first, and then a carriage return (0x0D). The 16-bit value is on `mem_addr` while a strobe is high and on `jump_addr` while `jump_req` is high.
- R2: After the carriage return of an erase line, `mem_erase` pulses for one cycle. The memory must raise `mem_busy` from the following cycle. A single `.` (0x2E) is then offered on the transmit port, and no transmit byte is offered while `mem_busy` is high.
- R3: A write line is followed by 128 hex digits and a carriage return, after which `mem_write` pulses once and a `.` follows as in R2. Digit pair 2b, 2b+1 forms page byte b, high nibble first. Byte b occupies `mem_wpage[8b+7:8b]`, so word k holds byte 2k in its low half and byte 2k+1 in its high half (low byte first).
- R4: A read line pulses `mem_read`. Once `mem_busy` is low, the engine captures `mem_rpage` and sends it as 128 upper-case hex characters in the byte and nibble order of R3, followed by one `.`.
- R5: A jump line pulses `jump_req` for one cycle with the address and sends nothing.
- R6: A line feed (0x0A) is discarded in every state and never counts as a bad character.
- R7: Inside a command, any byte that is not the expected one ends the command silently and returns the engine to idle. This covers lower-case hex, an upper-case command letter, or another byte where the carriage return belongs.
- R8: A `.` followed by a carriage return at any point of a partial command, including the middle of a write data line, cancels it with no strobe and no reply.
- R9: In idle, any byte other than the four command letters (carriage return, space, `.`, upper-case letters) is ignored.
- R10: From a strobe until the reply is finished, received bytes are consumed and ignored, and no new command starts.
- R11: `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low. A byte is transferred on a cycle where both are high.
- R12: After reset, every strobe, `jump_req` and `tx_valid` is low. At most one memory strobe is high in any cycle, and each strobe lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte offered |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| mem_erase | output | 1 | One-cycle page erase strobe |
| mem_write | output | 1 | One-cycle page write strobe |
| mem_read | output | 1 | One-cycle page read strobe |
| mem_addr | output | 16 | Page address for the strobes |
| mem_wpage | output | 512 | Page data to write, byte b at bits 8b+7:8b |
| mem_rpage | input | 512 | Page data read back, same layout |
| mem_busy | input | 1 | Memory operation in progress |
| jump_req | output | 1 | One-cycle transfer-of-control request |
| jump_addr | output | 16 | Target address of the jump |

## Verification
Some properties are checked by assertions on every cycle:
- no reply byte appears while the memory is busy or in the cycle after a strobe;
- memory strobes never overlap and last one cycle;
- the jump request is a single pulse;
- the offered reply byte holds during a stall.

Other behaviour can only be shown by the bench's scenarios, because it depends on whole byte sequences:
- digit and byte ordering of page data in both directions;
- silent rejection of lower-case digits, upper-case letters and a missing carriage return;
- the period-return abort in the middle of a write line;
- filler bytes ignored while busy.

// File: rtl/hexpage_pkg.sv
package hexpage_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_ADDR    = 4'd1,
        ST_ADDR_CR = 4'd2,
        ST_DATA    = 4'd3,
        ST_DATA_CR = 4'd4,
        ST_STROBE  = 4'd5,
        ST_WAIT    = 4'd6,
        ST_TX_HEX  = 4'd7,
        ST_TX_DOT  = 4'd8
    } state_e;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_JUMP  = 2'd3
    } op_e;

    localparam logic [7:0] CH_LF  = 8'h0A;
    localparam logic [7:0] CH_CR  = 8'h0D;
    localparam logic [7:0] CH_DOT = 8'h2E;
    localparam logic [7:0] CH_E   = 8'h65;
    localparam logic [7:0] CH_R   = 8'h72;
    localparam logic [7:0] CH_W   = 8'h77;
    localparam logic [7:0] CH_G   = 8'h67;

endpackage

// File: rtl/hexpage_hex_decode.sv
module hexpage_hex_decode (
    input  logic [7:0] ch,
    output logic       ok,
    output logic [3:0] nib
);
    always_comb begin
        ok  = 1'b0;
        nib = 4'd0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            ok  = 1'b1;
            nib = 4'(ch - 8'h30);
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            ok  = 1'b1;
            nib = 4'(ch - 8'h37);
        end
    end
endmodule

// File: rtl/hexpage_hex_encode.sv
module hexpage_hex_encode (
    input  logic [3:0] nib,
    output logic [7:0] ch
);
    always_comb begin
        if (nib < 4'd10) ch = 8'h30 + {4'd0, nib};
        else             ch = 8'h37 + {4'd0, nib};
    end
endmodule

// File: rtl/hexpage_cmd_engine.sv
module hexpage_cmd_engine
    import hexpage_pkg::*;
#(
    parameter int ADDR_DIGITS = 4,
    parameter int PAGE_WORDS  = 32,
    parameter int WORD_BITS   = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rx_valid,
    input  logic [7:0]                          rx_data,
    output logic                                tx_valid,
    output logic [7:0]                          tx_data,
    input  logic                                tx_ready,
    output logic                                mem_erase,
    output logic                                mem_write,
    output logic                                mem_read,
    output logic [4*ADDR_DIGITS-1:0]            mem_addr,
    output logic [PAGE_WORDS*WORD_BITS-1:0]     mem_wpage,
    input  logic [PAGE_WORDS*WORD_BITS-1:0]     mem_rpage,
    input  logic                                mem_busy,
    output logic                                jump_req,
    output logic [4*ADDR_DIGITS-1:0]            jump_addr
);
    localparam int ADDR_W    = 4 * ADDR_DIGITS;
    localparam int PAGE_BITS = PAGE_WORDS * WORD_BITS;
    localparam int NIBBLES   = PAGE_BITS / 4;
    localparam int CNT_W     = $clog2(NIBBLES);
    localparam logic [CNT_W-1:0] LAST_NIB  = CNT_W'(NIBBLES - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_DIGITS - 1);

    typedef struct packed {
        state_e                 st;
        op_e                    op;
        logic [CNT_W-1:0]       cnt;
        logic [ADDR_W-1:0]      addr;
        logic [PAGE_BITS-1:0]   pg;
        logic                   tx_v;
        logic [7:0]             tx_c;
        logic                   erase;
        logic                   write;
        logic                   read;
        logic                   jump;
    } regs_t;

    regs_t q, d;

    logic             dec_ok;
    logic [3:0]       dec_nib;
    logic [3:0]       enc_nib;
    logic [7:0]       enc_ch;
    logic [CNT_W-1:0] nidx;
    logic             byte_in;

    // Nibble position: within each byte the high nibble arrives first.
    assign nidx    = {q.cnt[CNT_W-1:1], ~q.cnt[0]};
    assign enc_nib = q.pg[{nidx, 2'b00} +: 4];
    assign byte_in = rx_valid && (rx_data != CH_LF);

    hexpage_hex_decode i_dec (.ch(rx_data), .ok(dec_ok), .nib(dec_nib));
    hexpage_hex_encode i_enc (.nib(enc_nib), .ch(enc_ch));

    always_comb begin
        d       = q;
        d.erase = 1'b0;
        d.write = 1'b0;
        d.read  = 1'b0;
        d.jump  = 1'b0;
        case (q.st)
            ST_IDLE: if (byte_in) begin
                d.cnt = '0;
                case (rx_data)
                    CH_E:    begin d.op = OP_ERASE; d.st = ST_ADDR; end
                    CH_R:    begin d.op = OP_READ;  d.st = ST_ADDR; end
                    CH_W:    begin d.op = OP_WRITE; d.st = ST_ADDR; end
                    CH_G:    begin d.op = OP_JUMP;  d.st = ST_ADDR; end
                    default: d.st = ST_IDLE;
                endcase
            end
            ST_ADDR: if (byte_in) begin
                if (dec_ok) begin
                    d.addr = {q.addr[ADDR_W-5:0], dec_nib};
                    if (q.cnt == LAST_ADDR) begin
                        d.st  = ST_ADDR_CR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_ADDR_CR: if (byte_in) begin
                if (rx_data == CH_CR) begin
                    case (q.op)
                        OP_ERASE: begin d.erase = 1'b1; d.st = ST_STROBE; end
                        OP_READ:  begin d.read  = 1'b1; d.st = ST_STROBE; end
                        OP_WRITE: begin d.st = ST_DATA; d.cnt = '0; end
                        default:  begin d.jump  = 1'b1; d.st = ST_IDLE; end
                    endcase
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_DATA: if (byte_in) begin
                if (dec_ok) begin
                    d.pg[{nidx, 2'b00} +: 4] = dec_nib;
                    if (q.cnt == LAST_NIB) begin
                        d.st  = ST_DATA_CR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_DATA_CR: if (byte_in) begin
                if (rx_data == CH_CR) begin
                    d.write = 1'b1;
                    d.st    = ST_STROBE;
                end else begin
                    d.st = ST_IDLE;
                end
            end
            ST_STROBE: d.st = ST_WAIT;
            ST_WAIT: if (!mem_busy) begin
                if (q.op == OP_READ) begin
                    d.pg  = mem_rpage;
                    d.cnt = '0;
                    d.st  = ST_TX_HEX;
                end else begin
                    d.st = ST_TX_DOT;
                end
            end
            ST_TX_HEX: begin
                if (!q.tx_v) begin
                    d.tx_v = 1'b1;
                    d.tx_c = enc_ch;
                end else if (tx_ready) begin
                    d.tx_v = 1'b0;
                    if (q.cnt == LAST_NIB) begin
                        d.st  = ST_TX_DOT;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_TX_DOT: begin
                if (!q.tx_v) begin
                    d.tx_v = 1'b1;
                    d.tx_c = CH_DOT;
                end else if (tx_ready) begin
                    d.tx_v = 1'b0;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_valid  = q.tx_v;
    assign tx_data   = q.tx_c;
    assign mem_erase = q.erase;
    assign mem_write = q.write;
    assign mem_read  = q.read;
    assign mem_addr  = q.addr;
    assign jump_addr = q.addr;
    assign jump_req  = q.jump;
    assign mem_wpage = q.pg;

    logic any_strobe;
    assign any_strobe = mem_erase | mem_write | mem_read;

    assert_no_reply_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> !mem_busy);

    assert_no_reply_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> !tx_valid);

    assert_jump_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |=> !jump_req);

    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_strobe_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_erase, mem_write, mem_read, jump_req}));

    assert_strobe_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> !any_strobe);

endmodule

// File: tb/test_hexpage_cmd_engine.sv
module test_hexpage_cmd_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_data = 8'h00;
    logic         tx_valid;
    logic [7:0]   tx_data;
    logic         tx_ready = 1'b0;
    logic         mem_erase, mem_write, mem_read;
    logic [15:0]  mem_addr;
    logic [511:0] mem_wpage;
    logic [511:0] model_page = '0;
    logic         mem_busy = 1'b0;
    logic         jump_req;
    logic [15:0]  jump_addr;

    always #2 clk = ~clk;

    hexpage_cmd_engine i_hexpage_cmd_engine (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .mem_erase(mem_erase), .mem_write(mem_write), .mem_read(mem_read),
        .mem_addr(mem_addr), .mem_wpage(mem_wpage), .mem_rpage(model_page),
        .mem_busy(mem_busy), .jump_req(jump_req), .jump_addr(jump_addr)
    );

    // Memory model: busy from the cycle after a strobe, for 40 cycles.
    int bcnt = 0;
    always @(posedge clk) begin
        if (mem_erase || mem_write || mem_read) begin
            mem_busy <= 1'b1;
            bcnt     <= 40;
            if (mem_write) model_page <= mem_wpage;
        end else if (bcnt > 0) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) mem_busy <= 1'b0;
        end
    end

    int checks = 0, fails = 0;
    int cyc = 0, n_erase = 0, n_write = 0, n_read = 0, n_jump = 0, n_dots = 0;
    int nch = 0, stall_err = 0, busy_err = 0, overlap_err = 0;
    logic [15:0] last_addr = '0, last_jaddr = '0;
    logic [7:0]  chars [256];
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_data = '0;

    // Monitor: drive tx_ready first, then judge the transfer at the coming edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        tx_ready = (cyc % 3) != 2;
        if (rst_n) begin
            if (prev_stall && (!tx_valid || tx_data != prev_data)) stall_err++;
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            if (int'(mem_erase) + int'(mem_write) + int'(mem_read) > 1) overlap_err++;
            if (mem_erase) begin n_erase++; last_addr = mem_addr; end
            if (mem_write) begin n_write++; last_addr = mem_addr; end
            if (mem_read)  begin n_read++;  last_addr = mem_addr; end
            if (jump_req)  begin n_jump++;  last_jaddr = jump_addr; end
            if (tx_valid && tx_ready) begin
                if (mem_busy) busy_err++;
                if (nch < 256) chars[nch] = tx_data;
                nch++;
                if (tx_data == 8'h2E) n_dots++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n);
        return (n < 4'd10) ? 8'h30 + {4'd0, n} : 8'h37 + {4'd0, n};
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // mode: 0 plain, 1 LF after 2nd digit, 2 lower-case third digit,
    //       3 junk instead of CR, 4 filler and abort prefix
    task automatic send_cmd(input logic [7:0] c, input logic [15:0] a, input int mode);
        if (mode == 4) begin
            send(8'h20); send(8'h2E); send(8'h0D); send(8'h0D); send(8'h41);
        end
        send(c);
        for (int i = 0; i < 4; i++) begin
            if (mode == 2 && i == 2) send(8'h61);
            else send(hexc(a[15-4*i -: 4]));
            if (mode == 1 && i == 1) send(8'h0A);
        end
        if (mode == 3) send(8'h5A);
        else send(8'h0D);
    endtask

    function automatic logic [7:0] pbyte(input int b);
        return 8'((b * 37 + 11) & 255);
    endfunction

    task automatic send_page_digits(input int nbytes);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] v;
            v = pbyte(b);
            send(hexc(v[7:4]));
            send(hexc(v[3:0]));
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]  cmd;
        logic [15:0] addr;
        logic [2:0]  mode;
        logic [1:0]  ex_erase;
        logic [1:0]  ex_jump;
        logic [1:0]  ex_dots;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h65, 16'h1234, 3'd0, 2'd1, 2'd0, 2'd1},   // R1 R2 erase
        '{8'h67, 16'hBEEF, 3'd0, 2'd0, 2'd1, 2'd0},   // R5 jump
        '{8'h65, 16'h0A5C, 3'd1, 2'd1, 2'd0, 2'd1},   // R6 LF inside
        '{8'h45, 16'h1234, 3'd0, 2'd0, 2'd0, 2'd0},   // R7 upper-case letter
        '{8'h65, 16'h12A4, 3'd2, 2'd0, 2'd0, 2'd0},   // R7 lower-case digit
        '{8'h67, 16'h4321, 3'd3, 2'd0, 2'd0, 2'd0},   // R7 missing CR
        '{8'h65, 16'hFFFF, 3'd4, 2'd1, 2'd0, 2'd1},   // R9 filler in idle
        '{8'h67, 16'h00C0, 3'd1, 2'd0, 2'd1, 2'd0}    // R6 LF in jump
    };

    logic [511:0] exp_page;
    int e0, w0, r0, j0, d0, bad;

    initial begin
        for (int b = 0; b < 64; b++) exp_page[8*b +: 8] = pbyte(b);
        idle(4);
        rst_n = 1'b1;
        idle(1);
        check(!tx_valid && !mem_erase && !mem_write && !mem_read && !jump_req,
              "R12 reset outputs", int'(tx_valid), 0);

        for (int v = 0; v < NV; v++) begin
            e0 = n_erase; j0 = n_jump; d0 = n_dots;
            send_cmd(VECS[v].cmd, VECS[v].addr, int'(VECS[v].mode));
            idle(80);
            check(n_erase - e0 == int'(VECS[v].ex_erase), "R1/R7 erase count", n_erase - e0, int'(VECS[v].ex_erase));
            check(n_jump - j0 == int'(VECS[v].ex_jump), "R5/R7 jump count", n_jump - j0, int'(VECS[v].ex_jump));
            check(n_dots - d0 == int'(VECS[v].ex_dots), "R2 reply count", n_dots - d0, int'(VECS[v].ex_dots));
            if (VECS[v].ex_erase != 0)
                check(last_addr == VECS[v].addr, "R1 erase address", int'(last_addr), int'(VECS[v].addr));
            if (VECS[v].ex_jump != 0)
                check(last_jaddr == VECS[v].addr, "R5 jump address", int'(last_jaddr), int'(VECS[v].addr));
        end

        // R3 page write, low byte first
        w0 = n_write; d0 = n_dots;
        send_cmd(8'h77, 16'h0340, 0);
        send_page_digits(64);
        send(8'h0D);
        idle(100);
        check(n_write - w0 == 1, "R3 write strobe", n_write - w0, 1);
        check(last_addr == 16'h0340, "R3 write address", int'(last_addr), 16'h0340);
        check(model_page == exp_page, "R3 page layout", int'(model_page[31:0]), int'(exp_page[31:0]));
        check(n_dots - d0 == 1, "R3 completion dot", n_dots - d0, 1);

        // R4 page read back as hex
        r0 = n_read; nch = 0;
        send_cmd(8'h72, 16'h0340, 0);
        idle(900);
        check(n_read - r0 == 1, "R4 read strobe", n_read - r0, 1);
        check(nch == 129, "R4 reply length", nch, 129);
        bad = 0;
        for (int b = 0; b < 64; b++) begin
            logic [7:0] v;
            v = exp_page[8*b +: 8];
            if (chars[2*b] != hexc(v[7:4]) || chars[2*b+1] != hexc(v[3:0])) bad++;
        end
        check(bad == 0, "R4 hex order", bad, 0);
        check(chars[128] == 8'h2E, "R4 final dot", int'(chars[128]), 8'h2E);

        // R8 abort in the middle of a write data line
        w0 = n_write; e0 = n_erase; d0 = n_dots;
        send_cmd(8'h77, 16'h0500, 0);
        send_page_digits(20);
        send(8'h2E); send(8'h0D);
        idle(60);
        check(n_write == w0 && n_dots == d0, "R8 abort no write", n_write - w0, 0);
        send_cmd(8'h65, 16'h0600, 0);
        idle(80);
        check(n_erase - e0 == 1, "R8 idle after abort", n_erase - e0, 1);

        // R10 bytes during busy are consumed
        r0 = n_read; d0 = n_dots;
        send_cmd(8'h65, 16'h0700, 0);
        send_cmd(8'h72, 16'h1000, 0);
        idle(120);
        check(n_read == r0, "R10 no command while busy", n_read - r0, 0);
        check(n_dots - d0 == 1, "R10 single reply", n_dots - d0, 1);

        // R7 write data not closed by CR
        w0 = n_write;
        send_cmd(8'h77, 16'h0800, 0);
        send_page_digits(64);
        send(8'h41); send(8'h0D);
        idle(80);
        check(n_write == w0, "R7 write without CR", n_write - w0, 0);

        check(busy_err == 0, "R2 reply while busy", busy_err, 0);
        check(stall_err == 0, "R11 stall hold", stall_err, 0);
        check(overlap_err == 0, "R12 strobe overlap", overlap_err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule